// File: doc/BRIEF.md
# Variable-Length Instruction Byte Queue

This block sits between a program-fetch port and an instruction decoder. On the fetch side it produces a stream of word-aligned fetch requests. Each request returns one 4-byte packet after a fixed latency, on a plain valid/data pair. The returned bytes go into a byte-granular circular store. On the decode side the block presents a 6-byte window that starts at the current instruction byte. Each cycle the decoder reports how many of those bytes (1 to 6) the current instruction used, and the window moves past them.

Fetching runs on its own, apart from consumption. A request goes out only when the store has room for that packet and for every packet still on its way back, so a returning packet always finds space. A redirect (a taken branch or an interrupt vector, for example) or a cache-control flush empties the store and marks all outstanding packets as stale. Fetching then restarts at the new address rounded down to a 4-byte boundary. The bytes that precede the target inside the first packet are dropped. A plain flush restarts at the current decode address, so decoding resumes at the same instruction.

Top module: `ibq_top`

## Requirements
- R1: After reset the occupancy is 0, the window is not valid, the current decode address equals the boot address, and a fetch request for the aligned boot address is raised in the first cycle.
- R2: Every fetch address is a multiple of 4. Each issued request advances the next fetch address by 4, so consecutive requests name consecutive packets.
- R3: A request is raised only while the free space is at least 4 bytes times one more than the number of live packets in flight. A stream of returning packets therefore never overflows the 64-byte store, and with no consumption the store fills to exactly 64 bytes from an aligned start and requests stop.
- R4: Byte k of a packet (data bits 8k+7 to 8k) belongs to fetch address + k. Byte i of the window (bits 8i+7 to 8i) is the byte at decode address + i.
- R5: The window is valid exactly when the requested length is between 1 and 6 and the occupancy is at least that length. Lengths 0 and 7 never give a valid window.
- R6: A consume of length L advances the decode address, the window and the read point by L, and lowers the occupancy by L. This happens only when L is between 1 and 6 and L is no more than the occupancy. Any other consume request leaves the decode address and the occupancy unchanged.
- R7: A redirect to address A empties the store at once and sets the decode address to A. The next request is for A rounded down to a multiple of 4, and the first A mod 4 bytes of that packet are skipped, so the store settles at 64 − (A mod 4) bytes.
- R8: A cache flush empties the store and refetches from the current decode address, with the same alignment and skip as R7. The decode address does not change.
- R9: No request is raised in a redirect or flush cycle. Packets requested before that cycle are discarded when they return and never reach the window.
- R10: The occupancy output equals the number of valid bytes from the decode address onward, and never exceeds 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_flush_i | input | 1 | Cache disabled or cleared: drop contents, refetch at decode address |
| redirect_i | input | 1 | Restart fetch and decode at redirect_addr_i |
| redirect_addr_i | input | 24 | Byte address of the redirect target |
| fetch_req_o | output | 1 | Request one 4-byte packet this cycle |
| fetch_addr_o | output | 24 | Aligned byte address of the requested packet |
| fetch_rsp_valid_i | input | 1 | A requested packet returns this cycle, in request order |
| fetch_rsp_data_i | input | 32 | Returned packet, lowest address in bits 7:0 |
| need_len_i | input | 3 | Bytes the decoder needs to see (1 to 6) |
| take_en_i | input | 1 | Decoder consumes bytes this cycle |
| take_len_i | input | 3 | Number of bytes consumed (1 to 6) |
| win_valid_o | output | 1 | Window holds at least need_len_i valid bytes |
| win_data_o | output | 48 | Six bytes from the decode address, first byte in bits 7:0 |
| cur_pc_o | output | 24 | Byte address of the first window byte |
| occupancy_o | output | 7 | Valid bytes held from the decode address onward |

## Verification
The embedded properties check several rules on every cycle. Fetch addresses stay aligned and step by 4 after each request. No request is raised in a restart cycle. A packet is never written when fewer than 4 bytes are free. An accepted consume lowers the occupancy by exactly its length. A restart leaves the store empty, with the decode address and the next fetch address set from the target. Other behaviour only the directed scenarios can show: whether the bytes in the window match memory contents, and whether stale packets are actually dropped after a redirect issued while requests are in flight. The scenarios also cover the settled fill level after an unaligned restart and the wrap of the read point during a long mixed-length consume run.

// File: rtl/ibq_pkg.sv
package ibq_pkg;
    localparam int unsigned PKT_BYTES = 4;
    localparam int unsigned WIN_BYTES = 6;
    localparam int unsigned LEN_W     = 3;
    localparam int unsigned OFF_W     = $clog2(PKT_BYTES);
endpackage

// File: rtl/ibq_fetch_ctl.sv
module ibq_fetch_ctl
    import ibq_pkg::*;
#(
    parameter int unsigned AW        = 24,
    parameter int unsigned DEPTH     = 64,
    parameter logic [AW-1:0] BOOT_ADDR = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        restart_i,
    input  logic [AW-1:0]               restart_addr_i,
    input  logic [$clog2(DEPTH+1)-1:0]  free_i,
    input  logic                        rsp_valid_i,
    output logic                        req_o,
    output logic [AW-1:0]               addr_o,
    output logic                        live_o
);
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1);
    localparam int unsigned OUT_W   = $clog2(DEPTH / PKT_BYTES + 1);
    localparam int unsigned STALE_W = OUT_W + 1;
    localparam int unsigned NEED_W  = CNT_W + 2;

    typedef struct packed {
        logic [AW-1:0]      addr;
        logic [OUT_W-1:0]   live;
        logic [STALE_W-1:0] stale;
    } fst_t;

    fst_t q, d;
    logic [NEED_W-1:0] need_bytes;
    logic              room;
    logic              rsp_stale;

    always_comb begin
        d          = q;
        need_bytes = (NEED_W'(q.live) + NEED_W'(1)) << OFF_W;
        room       = NEED_W'(free_i) >= need_bytes;
        req_o      = !restart_i && room;
        rsp_stale  = rsp_valid_i && (q.stale != '0);
        live_o     = rsp_valid_i && (q.stale == '0) && !restart_i;
        if (restart_i) begin
            d.addr  = {restart_addr_i[AW-1:OFF_W], {OFF_W{1'b0}}};
            d.stale = STALE_W'(q.live) + q.stale - STALE_W'(rsp_valid_i);
            d.live  = '0;
        end else begin
            d.stale = q.stale - STALE_W'(rsp_stale);
            d.live  = q.live + OUT_W'(req_o) - OUT_W'(live_o);
            if (req_o) begin
                d.addr = q.addr + AW'(PKT_BYTES);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.addr  <= {BOOT_ADDR[AW-1:OFF_W], {OFF_W{1'b0}}};
            q.live  <= '0;
            q.stale <= '0;
        end else begin
            q <= d;
        end
    end

    assign addr_o = q.addr;

    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_o[OFF_W-1:0] == '0);
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> addr_o == $past(addr_o) + AW'(PKT_BYTES));
    p_no_req_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |-> !req_o);
    p_restart_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> addr_o[AW-1:OFF_W] == $past(restart_addr_i[AW-1:OFF_W]));
endmodule

// File: rtl/ibq_store.sv
module ibq_store
    import ibq_pkg::*;
#(
    parameter int unsigned AW        = 24,
    parameter int unsigned DEPTH     = 64,
    parameter logic [AW-1:0] BOOT_ADDR = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        restart_i,
    input  logic [AW-1:0]               restart_addr_i,
    input  logic                        pkt_valid_i,
    input  logic [8*PKT_BYTES-1:0]      pkt_data_i,
    input  logic [LEN_W-1:0]            take_i,
    output logic [$clog2(DEPTH):0]      occ_o,
    output logic [AW-1:0]               pc_o,
    output logic [8*WIN_BYTES-1:0]      win_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W:0]        wptr;
        logic [PTR_W:0]        rptr;
        logic [OFF_W-1:0]      skip;
        logic                  skip_pend;
        logic [AW-1:0]         pc;
    } sst_t;

    sst_t q, d;
    logic [PTR_W:0] adv;

    always_comb begin
        d   = q;
        adv = (PTR_W+1)'(take_i);
        if (restart_i) begin
            d.wptr      = '0;
            d.rptr      = '0;
            d.skip      = restart_addr_i[OFF_W-1:0];
            d.skip_pend = 1'b1;
            d.pc        = restart_addr_i;
        end else begin
            if (pkt_valid_i) begin
                for (int k = 0; k < PKT_BYTES; k++) begin
                    d.mem[PTR_W'(q.wptr[PTR_W-1:0] + PTR_W'(k))] = pkt_data_i[8*k +: 8];
                end
                d.wptr = q.wptr + (PTR_W+1)'(PKT_BYTES);
                if (q.skip_pend) begin
                    adv         = adv + (PTR_W+1)'(q.skip);
                    d.skip_pend = 1'b0;
                end
            end
            d.rptr = q.rptr + adv;
            d.pc   = q.pc + AW'(take_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mem       <= '0;
            q.wptr      <= '0;
            q.rptr      <= '0;
            q.skip      <= BOOT_ADDR[OFF_W-1:0];
            q.skip_pend <= 1'b1;
            q.pc        <= BOOT_ADDR;
        end else begin
            q <= d;
        end
    end

    assign occ_o = q.wptr - q.rptr;
    assign pc_o  = q.pc;

    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_win
        assign win_o[8*i +: 8] = q.mem[PTR_W'(q.rptr[PTR_W-1:0] + PTR_W'(i))];
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid_i && !restart_i) |-> occ_o <= (PTR_W+1)'(DEPTH - PKT_BYTES));
    p_occ_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        occ_o <= (PTR_W+1)'(DEPTH));
    p_skip_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.skip_pend |-> occ_o == '0);
    p_take_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i != '0) |-> (PTR_W+1)'(take_i) <= occ_o);
endmodule

// File: rtl/ibq_window.sv
module ibq_window
    import ibq_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic [CNT_W-1:0] occ_i,
    input  logic [LEN_W-1:0] need_i,
    input  logic             take_en_i,
    input  logic [LEN_W-1:0] take_len_i,
    input  logic             restart_i,
    output logic             win_valid_o,
    output logic [LEN_W-1:0] take_o
);
    logic need_ok;
    logic take_ok;

    always_comb begin
        need_ok     = (need_i != '0) && (need_i <= LEN_W'(WIN_BYTES));
        win_valid_o = need_ok && (CNT_W'(need_i) <= occ_i);
        take_ok     = take_en_i && !restart_i && (take_len_i != '0)
                      && (take_len_i <= LEN_W'(WIN_BYTES))
                      && (CNT_W'(take_len_i) <= occ_i);
        take_o      = take_ok ? take_len_i : '0;
    end
endmodule

// File: rtl/ibq_top.sv
module ibq_top
    import ibq_pkg::*;
#(
    parameter int unsigned AW        = 24,
    parameter int unsigned DEPTH     = 64,
    parameter logic [AW-1:0] BOOT_ADDR = '0,
    localparam int unsigned CNT_W    = $clog2(DEPTH) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cache_flush_i,
    input  logic                   redirect_i,
    input  logic [AW-1:0]          redirect_addr_i,
    output logic                   fetch_req_o,
    output logic [AW-1:0]          fetch_addr_o,
    input  logic                   fetch_rsp_valid_i,
    input  logic [8*PKT_BYTES-1:0] fetch_rsp_data_i,
    input  logic [LEN_W-1:0]       need_len_i,
    input  logic                   take_en_i,
    input  logic [LEN_W-1:0]       take_len_i,
    output logic                   win_valid_o,
    output logic [8*WIN_BYTES-1:0] win_data_o,
    output logic [AW-1:0]          cur_pc_o,
    output logic [CNT_W-1:0]       occupancy_o
);
    logic             restart;
    logic [AW-1:0]    restart_addr;
    logic [CNT_W-1:0] free_bytes;
    logic             pkt_live;
    logic [LEN_W-1:0] take_amt;

    assign restart      = cache_flush_i || redirect_i;
    assign restart_addr = redirect_i ? redirect_addr_i : cur_pc_o;
    assign free_bytes   = CNT_W'(DEPTH) - occupancy_o;

    ibq_fetch_ctl #(.AW(AW), .DEPTH(DEPTH), .BOOT_ADDR(BOOT_ADDR)) u_fetch (
        .clk            (clk),
        .rst_n          (rst_n),
        .restart_i      (restart),
        .restart_addr_i (restart_addr),
        .free_i         (free_bytes),
        .rsp_valid_i    (fetch_rsp_valid_i),
        .req_o          (fetch_req_o),
        .addr_o         (fetch_addr_o),
        .live_o         (pkt_live)
    );

    ibq_store #(.AW(AW), .DEPTH(DEPTH), .BOOT_ADDR(BOOT_ADDR)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .restart_i      (restart),
        .restart_addr_i (restart_addr),
        .pkt_valid_i    (pkt_live),
        .pkt_data_i     (fetch_rsp_data_i),
        .take_i         (take_amt),
        .occ_o          (occupancy_o),
        .pc_o           (cur_pc_o),
        .win_o          (win_data_o)
    );

    ibq_window #(.CNT_W(CNT_W)) u_window (
        .occ_i       (occupancy_o),
        .need_i      (need_len_i),
        .take_en_i   (take_en_i),
        .take_len_i  (take_len_i),
        .restart_i   (restart),
        .win_valid_o (win_valid_o),
        .take_o      (take_amt)
    );

    p_occ_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_amt != '0 && !pkt_live && !restart)
        |=> occupancy_o == $past(occupancy_o) - CNT_W'($past(take_amt)));
    p_pc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_amt == '0 && !restart) |=> cur_pc_o == $past(cur_pc_o));
    p_restart_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> occupancy_o == '0);
    p_redirect_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> cur_pc_o == $past(redirect_addr_i));
endmodule

// File: tb/tb_ibq_top.sv
module tb_ibq_top;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_flush = 1'b0;
    logic        redirect = 1'b0;
    logic [23:0] redirect_addr = '0;
    logic        fetch_req;
    logic [23:0] fetch_addr;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic [2:0]  need_len = 3'd1;
    logic        take_en = 1'b0;
    logic [2:0]  take_len = '0;
    logic        win_valid;
    logic [47:0] win_data;
    logic [23:0] cur_pc;
    logic [6:0]  occupancy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ibq_top dut (
        .clk(clk), .rst_n(rst_n), .cache_flush_i(cache_flush),
        .redirect_i(redirect), .redirect_addr_i(redirect_addr),
        .fetch_req_o(fetch_req), .fetch_addr_o(fetch_addr),
        .fetch_rsp_valid_i(rsp_valid), .fetch_rsp_data_i(rsp_data),
        .need_len_i(need_len), .take_en_i(take_en), .take_len_i(take_len),
        .win_valid_o(win_valid), .win_data_o(win_data),
        .cur_pc_o(cur_pc), .occupancy_o(occupancy)
    );

    function automatic logic [7:0] fb(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] pkt(input logic [23:0] a);
        return {fb(a + 24'd3), fb(a + 24'd2), fb(a + 24'd1), fb(a)};
    endfunction

    function automatic logic [47:0] exp_win(input logic [23:0] pc, input int n);
        logic [47:0] w = '0;
        for (int i = 0; i < n; i++) w[8*i +: 8] = fb(pc + 24'(i));
        return w;
    endfunction

    function automatic logic [47:0] mask(input int n);
        logic [47:0] m = '0;
        for (int i = 0; i < n; i++) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    // Memory model: fixed-latency in-order responses, driven at the falling edge.
    logic [LAT-1:0] p_v = '0;
    logic [23:0]    p_a [LAT];
    always @(negedge clk) begin
        if (!rst_n) begin
            p_v       <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= p_v[LAT-1];
            rsp_data  <= pkt(p_a[LAT-1]);
            p_v       <= {p_v[LAT-2:0], fetch_req};
            p_a[0]    <= fetch_addr;
            for (int i = 1; i < LAT; i++) p_a[i] <= p_a[i-1];
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic take_once(input logic [2:0] len);
        @(negedge clk);
        take_en = 1'b1; take_len = len;
        @(negedge clk);
        take_en = 1'b0; take_len = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(3);
        chk("R1 occupancy", 64'(occupancy), 64'd0);
        chk("R1 win_valid", 64'(win_valid), 64'd0);
        chk("R1 cur_pc", 64'(cur_pc), 64'd0);
        rst_n = 1'b1;
        #1;
        chk("R1 first req", 64'(fetch_req), 64'd1);
        chk("R1 first addr", 64'(fetch_addr), 64'd0);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            chk("R2 addr step", 64'(fetch_addr), 64'(4 * k));
        end
    endtask

    task automatic t_fill;
        idle(40);
        chk("R3 full occupancy", 64'(occupancy), 64'd64);
        chk("R3 no req when full", 64'(fetch_req), 64'd0);
        chk("R10 occupancy full", 64'(occupancy), 64'd64);
        chk("R4 window bytes", 64'(win_data), 64'(exp_win(24'd0, 6)));
    endtask

    task automatic t_need;
        need_len = 3'd0; #1;
        chk("R5 need 0", 64'(win_valid), 64'd0);
        need_len = 3'd7; #1;
        chk("R5 need 7", 64'(win_valid), 64'd0);
        need_len = 3'd6; #1;
        chk("R5 need 6", 64'(win_valid), 64'd1);
        need_len = 3'd1;
    endtask

    task automatic t_consume;
        logic [23:0] pc;
        logic [6:0]  occ0;
        for (int len = 1; len <= 6; len++) begin
            idle(12);
            pc = cur_pc; occ0 = occupancy;
            take_once(3'(len));
            chk("R6 pc advance", 64'(cur_pc), 64'(pc + 24'(len)));
            chk("R6 occupancy drop", 64'(occupancy), 64'(occ0 - 7'(len)));
            chk("R4 window after take", 64'(win_data), 64'(exp_win(pc + 24'(len), 6)));
        end
    endtask

    task automatic t_ignore;
        logic [23:0] pc;
        logic [6:0]  occ0;
        idle(12);
        pc = cur_pc; occ0 = occupancy;
        take_once(3'd7);
        chk("R6 len 7 ignored pc", 64'(cur_pc), 64'(pc));
        chk("R6 len 7 ignored occ", 64'(occupancy), 64'(occ0));
        take_once(3'd0);
        chk("R6 len 0 ignored pc", 64'(cur_pc), 64'(pc));
        chk("R6 len 0 ignored occ", 64'(occupancy), 64'(occ0));
    endtask

    task automatic t_redirect(input logic [23:0] a);
        take_once(3'd6);           // frees space so a refill request is outstanding
        @(negedge clk);
        redirect = 1'b1; redirect_addr = a;
        #1;
        chk("R9 no req in redirect cycle", 64'(fetch_req), 64'd0);
        @(negedge clk);
        redirect = 1'b0;
        chk("R7 emptied", 64'(occupancy), 64'd0);
        chk("R7 pc", 64'(cur_pc), 64'(a));
        chk("R7 aligned refetch", 64'(fetch_addr), 64'({a[23:2], 2'b00}));
        chk("R5 empty not valid", 64'(win_valid), 64'd0);
        take_en = 1'b1; take_len = 3'd3;     // occupancy is 0: must be ignored
        @(negedge clk);
        take_en = 1'b0; take_len = '0;
        chk("R6 take on empty ignored", 64'(cur_pc), 64'(a));
        idle(40);
        chk("R7 settled occupancy", 64'(occupancy), 64'(64 - a[1:0]));
        chk("R9 R4 stale dropped window", 64'(win_data), 64'(exp_win(a, 6)));
    endtask

    task automatic t_flush;
        logic [23:0] pc;
        take_once(3'd2);
        pc = cur_pc;
        @(negedge clk);
        cache_flush = 1'b1;
        #1;
        chk("R9 no req in flush cycle", 64'(fetch_req), 64'd0);
        @(negedge clk);
        cache_flush = 1'b0;
        chk("R8 emptied", 64'(occupancy), 64'd0);
        chk("R8 pc kept", 64'(cur_pc), 64'(pc));
        chk("R8 aligned refetch", 64'(fetch_addr), 64'({pc[23:2], 2'b00}));
        idle(40);
        chk("R8 settled occupancy", 64'(occupancy), 64'(64 - pc[1:0]));
        chk("R8 window", 64'(win_data), 64'(exp_win(pc, 6)));
    endtask

    task automatic t_stream;
        logic [23:0] pc;
        int taken = 0;
        pc = cur_pc;
        for (int it = 0; it < 150; it++) begin
            int len = (it % 6) + 1;
            @(negedge clk);
            take_en = 1'b0; take_len = '0;
            need_len = 3'(len);
            #1;
            if (win_valid) begin
                chk("R4 R6 stream window", 64'(win_data & mask(len)), 64'(exp_win(pc, len)));
                take_en = 1'b1; take_len = 3'(len);
                pc = pc + 24'(len);
                taken++;
            end
        end
        @(negedge clk);
        take_en = 1'b0; take_len = '0; need_len = 3'd1;
        chk("R6 stream pc", 64'(cur_pc), 64'(pc));
        chk("R10 stream wrapped", 64'(taken > 60), 64'd1);
    endtask

    initial begin
        t_reset;
        t_fill;
        t_need;
        t_consume;
        t_ignore;
        t_redirect(24'h12_3457);
        t_flush;
        t_redirect(24'h00_0402);
        t_stream;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule